// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, made of a segment number and an offset, into a physical address. The description of each segment sits in a table in memory. A table-origin register gives the address of entry zero, and a segment-count register gives how many entries are legal. For each request the block first checks the segment number against the count. If the number is legal, it takes the entry either from a one-entry local copy or from a single memory read. It then checks the entry's valid flag, its access rights and its length. The result is either base plus offset or a fault code that names the first check that failed.

A processor-side requester presents one request at a time when the block is ready and receives a single-cycle response. The table registers are written through a simple write strobe. Any write to them discards the local entry copy, so a stale description is never used after the table has moved or shrunk.

Top module: `seg_translator`

## Requirements
- R1: After reset, `rspValid` and `memRdEn` are 0, `reqReady` is 1, both table registers are 0 and the local entry copy is empty.
- R2: A write with `cfgWrEn`=1 loads `cfgData` into the table origin when `cfgSel`=0, and loads `cfgData[SEG_W:0]` into the segment count when `cfgSel`=1.
- R3: A segment number not below the segment count returns fault code 1 with no memory read, and the response appears on the second clock edge after the request is accepted.
- R4: On a lookup miss the block raises `memRdEn` for exactly one cycle, with `memRdAddr` = table origin + segment number. The entry word it reads holds the base in bits [PA_W-1:0], the limit in the next OFF_W bits, then the read, write, execute and valid flags, with valid as the most significant bit.
- R5: An entry whose valid flag is 0 returns fault code 2, whatever its rights and limit.
- R6: Access code 0 (read), 1 (write) or 2 (execute) needs the matching right flag, and code 3 is never allowed. A denied access returns fault code 3, which takes priority over a limit violation.
- R7: An offset equal to or greater than the entry's limit returns fault code 4.
- R8: A legal access returns fault code 0 and `rspPhys` = base + offset modulo 2^PA_W. Every faulted response carries `rspPhys` = 0.
- R9: A request whose segment matches the retained entry makes no memory read and responds on the second clock edge after acceptance. A miss responds on the edge after `memRdValid`, and the fetched entry is then retained.
- R10: Any table-register write empties the retained entry. A write during the check cycle delays the check by one cycle so the check uses the new values. A write while a read is outstanding, including in the cycle the data returns, still lets that request complete from the fetched entry but keeps the entry from being retained.
- R11: Each accepted request yields exactly one single-cycle `rspValid` pulse, and `reqReady` is 0 from acceptance until the response is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Table-register write strobe |
| cfgSel | input | 1 | 0 selects table origin, 1 selects segment count |
| cfgData | input | PA_W | Write data for the table registers |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqSeg | input | SEG_W | Segment number |
| reqOffset | input | OFF_W | Offset within the segment |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| memRdEn | output | 1 | Table entry read request |
| memRdAddr | output | PA_W | Address of the table entry |
| memRdValid | input | 1 | Entry data returned |
| memRdData | input | PA_W+OFF_W+4 | Returned entry word |
| rspValid | output | 1 | Single-cycle response strobe |
| rspFault | output | 3 | 0 ok, 1 range, 2 invalid, 3 rights, 4 limit |
| rspPhys | output | PA_W | Translated physical address, 0 on fault |

## Verification
A table-register write can land in the same cycle as a lookup decision or as an entry fill. These are the two actions that share the retained-entry register. The bench issues writes in the check cycle, in the first outstanding-read cycle and in the exact cycle the memory returns data. It judges the outcome by the response latency, by whether the next request to the same segment reads memory again, and by the fault code that results from the updated count.

// File: rtl/segxlt_pkg.sv
package segxlt_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accessE;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_PRIV    = 3'd3,
    FLT_LIMIT   = 3'd4
  } faultE;

  typedef struct packed {
    logic latchReq;
    logic useCache;
    logic respondRange;
    logic respondEntry;
    logic fillCache;
  } ctlStrobesT;

endpackage

// File: rtl/segxlt_datapath.sv
module segxlt_datapath
  import segxlt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  localparam int ENT_W = PA_W + OFF_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [PA_W-1:0]  cfgData,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOffset,
  input  accessE           reqAccess,
  input  ctlStrobesT       ctl,
  input  logic [ENT_W-1:0] memRdData,
  output logic             segInRange,
  output logic             cacheHit,
  output logic [PA_W-1:0]  memRdAddr,
  output logic             rspValid,
  output faultE            rspFault,
  output logic [PA_W-1:0]  rspPhys
);

  localparam int CNT_W   = SEG_W + 1;
  localparam int LIM_LSB = PA_W;
  localparam int RD_BIT  = PA_W + OFF_W;
  localparam int WR_BIT  = RD_BIT + 1;
  localparam int EX_BIT  = RD_BIT + 2;
  localparam int VAL_BIT = RD_BIT + 3;

  logic [PA_W-1:0]  tableBase;
  logic [CNT_W-1:0] segCount;
  logic [SEG_W-1:0] segQ;
  logic [OFF_W-1:0] offQ;
  accessE           accQ;
  logic             cacheValid;
  logic [SEG_W-1:0] cacheSeg;
  logic [ENT_W-1:0] cacheEntry;

  logic [ENT_W-1:0] evalEntry;
  logic [PA_W-1:0]  entBase;
  logic [OFF_W-1:0] entLimit;
  logic             entValid;
  logic             rightOk;
  faultE            entryFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= '0;
      segCount  <= '0;
    end else if (cfgWrEn) begin
      if (!cfgSel) tableBase <= cfgData;
      else         segCount  <= cfgData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segQ <= '0;
      offQ <= '0;
      accQ <= ACC_READ;
    end else if (ctl.latchReq) begin
      segQ <= reqSeg;
      offQ <= reqOffset;
      accQ <= reqAccess;
    end
  end

  assign segInRange = {1'b0, segQ} < segCount;
  assign memRdAddr  = tableBase + PA_W'(segQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheValid <= 1'b0;
      cacheSeg   <= '0;
      cacheEntry <= '0;
    end else if (cfgWrEn) begin
      cacheValid <= 1'b0;
    end else if (ctl.fillCache) begin
      cacheValid <= 1'b1;
      cacheSeg   <= segQ;
      cacheEntry <= memRdData;
    end
  end

  assign cacheHit = cacheValid && (cacheSeg == segQ);

  assign evalEntry = ctl.useCache ? cacheEntry : memRdData;
  assign entBase   = evalEntry[PA_W-1:0];
  assign entLimit  = evalEntry[LIM_LSB +: OFF_W];
  assign entValid  = evalEntry[VAL_BIT];

  always_comb begin
    unique case (accQ)
      ACC_READ:  rightOk = evalEntry[RD_BIT];
      ACC_WRITE: rightOk = evalEntry[WR_BIT];
      ACC_EXEC:  rightOk = evalEntry[EX_BIT];
      default:   rightOk = 1'b0;
    endcase
  end

  always_comb begin
    if (!entValid)              entryFault = FLT_INVALID;
    else if (!rightOk)          entryFault = FLT_PRIV;
    else if (offQ >= entLimit)  entryFault = FLT_LIMIT;
    else                        entryFault = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
      rspPhys  <= '0;
    end else begin
      rspValid <= ctl.respondRange | ctl.respondEntry;
      if (ctl.respondRange) begin
        rspFault <= FLT_RANGE;
        rspPhys  <= '0;
      end else if (ctl.respondEntry) begin
        rspFault <= entryFault;
        rspPhys  <= (entryFault == FLT_NONE) ? entBase + PA_W'(offQ) : '0;
      end
    end
  end

  assert_cfg_clears_copy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> !cacheValid);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_fault_zero_phys_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != FLT_NONE) |-> (rspPhys == '0));

  assert_hit_needs_copy_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useCache |-> cacheValid);

endmodule

// File: rtl/segxlt_control.sv
module segxlt_control
  import segxlt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cfgWrEn,
  input  logic       memRdValid,
  input  logic       segInRange,
  input  logic       cacheHit,
  output logic       reqReady,
  output logic       memRdEn,
  output ctlStrobesT ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_WAIT} stateE;

  stateE stateQ, stateD;
  logic  staleQ;

  always_comb begin
    stateD   = stateQ;
    reqReady = 1'b0;
    memRdEn  = 1'b0;
    ctl      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateD       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (cfgWrEn) begin
          stateD = ST_LOOKUP;
        end else if (!segInRange) begin
          ctl.respondRange = 1'b1;
          stateD           = ST_IDLE;
        end else if (cacheHit) begin
          ctl.useCache     = 1'b1;
          ctl.respondEntry = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          memRdEn = 1'b1;
          stateD  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRdValid) begin
          ctl.respondEntry = 1'b1;
          ctl.fillCache    = !staleQ && !cfgWrEn;
          stateD           = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      staleQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (memRdEn)                          staleQ <= 1'b0;
      else if (stateQ == ST_WAIT && cfgWrEn) staleQ <= 1'b1;
    end
  end

  assert_read_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_read_on_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.respondRange |-> !memRdEn);

endmodule

// File: rtl/seg_translator.sv
module seg_translator
  import segxlt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  localparam int ENT_W = PA_W + OFF_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [PA_W-1:0]  cfgData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [1:0]       reqAccess,
  output logic             memRdEn,
  output logic [PA_W-1:0]  memRdAddr,
  input  logic             memRdValid,
  input  logic [ENT_W-1:0] memRdData,
  output logic             rspValid,
  output logic [2:0]       rspFault,
  output logic [PA_W-1:0]  rspPhys
);

  ctlStrobesT ctl;
  logic       segInRange;
  logic       cacheHit;
  faultE      faultInt;

  segxlt_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .cfgWrEn    (cfgWrEn),
    .memRdValid (memRdValid),
    .segInRange (segInRange),
    .cacheHit   (cacheHit),
    .reqReady   (reqReady),
    .memRdEn    (memRdEn),
    .ctl        (ctl)
  );

  segxlt_datapath #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgData    (cfgData),
    .reqSeg     (reqSeg),
    .reqOffset  (reqOffset),
    .reqAccess  (accessE'(reqAccess)),
    .ctl        (ctl),
    .memRdData  (memRdData),
    .segInRange (segInRange),
    .cacheHit   (cacheHit),
    .memRdAddr  (memRdAddr),
    .rspValid   (rspValid),
    .rspFault   (faultInt),
    .rspPhys    (rspPhys)
  );

  assign rspFault = faultInt;

endmodule

// File: tb/test_seg_translator.sv
module test_seg_translator;

  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 4;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int ENT_W = PA_W + OFF_W + 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic             cfgSel = 1'b0;
  logic [PA_W-1:0]  cfgData = '0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [SEG_W-1:0] reqSeg = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [1:0]       reqAccess = '0;
  logic             memRdEn;
  logic [PA_W-1:0]  memRdAddr;
  logic             memRdValid;
  logic [ENT_W-1:0] memRdData;
  logic             rspValid;
  logic [2:0]       rspFault;
  logic [PA_W-1:0]  rspPhys;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_translator #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_translator (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqSeg(reqSeg), .reqOffset(reqOffset),
    .reqAccess(reqAccess), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .rspValid(rspValid),
    .rspFault(rspFault), .rspPhys(rspPhys)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdCount = 0;
  int rspCount = 0;
  int lastRspCyc = 0;
  int reqCount = 0;
  logic [PA_W-1:0] lastRdAddr = '0;

  // Memory model: two-cycle read latency
  logic [ENT_W-1:0] mem [64];
  logic             pv1 = 1'b0, pv2 = 1'b0;
  logic [ENT_W-1:0] pd1 = '0, pd2 = '0;
  assign memRdValid = pv2;
  assign memRdData  = pd2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      pv1 <= 1'b0; pv2 <= 1'b0;
    end else begin
      pv1 <= memRdEn;
      pd1 <= mem[memRdAddr[5:0]];
      pv2 <= pv1;
      pd2 <= pd1;
      if (memRdEn) begin
        rdCount = rdCount + 1;
        lastRdAddr = memRdAddr;
      end
    end
  end

  function automatic logic [ENT_W-1:0] mkEnt(input logic v, input logic x, input logic w,
                                              input logic r, input logic [OFF_W-1:0] lim,
                                              input logic [PA_W-1:0] base);
    return {v, x, w, r, lim, base};
  endfunction

  typedef struct {
    logic [2:0]      f;
    logic [PA_W-1:0] p;
    string           tag;
  } expT;
  expT q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspCount++;
      lastRspCyc = cyc;
      if (q.size() == 0) begin
        chk(1'b0, "R11 response with nothing expected", 1, 0);
      end else begin
        expT e;
        e = q.pop_front();
        chk(rspFault == e.f, {e.tag, " fault"}, int'(rspFault), int'(e.f));
        chk(rspPhys == e.p, {e.tag, " phys"}, int'(rspPhys), int'(e.p));
      end
    end
  end

  task automatic cfgWrite(input logic sel, input logic [PA_W-1:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Driver: pushes the expectation, drives one request, optionally a
  // table write k negedges later, then checks read count and latency.
  task automatic doReq(input logic [SEG_W-1:0] seg, input logic [OFF_W-1:0] off,
                       input logic [1:0] acc, input logic [2:0] ef, input logic [PA_W-1:0] ep,
                       input int expReads, input int expLat, input string tag,
                       input int cfgK = 0, input logic cSel = 1'b0,
                       input logic [PA_W-1:0] cVal = '0);
    expT e;
    int rd0, n0, accCyc;
    e.f = ef; e.p = ep; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rd0 = rdCount; n0 = rspCount; accCyc = cyc;
    reqValid = 1'b1; reqSeg = seg; reqOffset = off; reqAccess = acc;
    reqCount++;
    for (int k = 1; k <= cfgK + 1; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (k == cfgK) begin cfgWrEn = 1'b1; cfgSel = cSel; cfgData = cVal; end
      else cfgWrEn = 1'b0;
    end
    if (cfgK == 0) begin @(negedge clk); reqValid = 1'b0; end
    wait (rspCount == n0 + 1);
    chk(rdCount - rd0 == expReads, {tag, " memory reads"}, rdCount - rd0, expReads);
    if (expLat > 0)
      chk(lastRspCyc - accCyc == expLat, {tag, " latency"}, lastRspCyc - accCyc, expLat);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0] = mkEnt(1, 0, 0, 1, 12'h100, 16'h1000);
    mem[1] = mkEnt(1, 1, 1, 1, 12'h800, 16'hF900);
    mem[2] = mkEnt(0, 1, 1, 1, 12'h000, 16'h5000);
    mem[3] = mkEnt(1, 1, 0, 0, 12'h010, 16'h2000);
    mem[9] = mkEnt(1, 0, 1, 1, 12'h020, 16'h3000);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rspValid == 1'b0, "R1 rspValid after reset", rspValid, 0);
    chk(memRdEn == 1'b0, "R1 memRdEn after reset", memRdEn, 0);
    chk(reqReady == 1'b1, "R1 reqReady in reset", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    // R1: count is 0, so any segment is out of range
    doReq(0, 0, 0, 3'd1, 16'h0, 0, 2, "R1 zero count range");

    // R2 configure origin 0x40, count 4
    cfgWrite(1'b0, 16'h0040);
    cfgWrite(1'b1, 16'h0004);

    doReq(0, 12'h010, 0, 3'd0, 16'h1010, 1, 4, "R9 R8 miss seg0 read");
    chk(lastRdAddr == 16'h0040, "R4 entry address seg0", lastRdAddr, 16'h0040);
    doReq(0, 12'h020, 0, 3'd0, 16'h1020, 0, 2, "R9 hit seg0");
    doReq(0, 12'h020, 1, 3'd3, 16'h0, 0, 2, "R6 write denied");
    doReq(0, 12'h100, 0, 3'd4, 16'h0, 0, 2, "R7 offset at limit");
    doReq(0, 12'h0FF, 0, 3'd0, 16'h10FF, 0, 2, "R7 offset below limit");
    doReq(4, 12'h000, 0, 3'd1, 16'h0, 0, 2, "R3 seg equals count");
    doReq(15, 12'h000, 2, 3'd1, 16'h0, 0, 2, "R3 top seg");
    doReq(2, 12'h005, 0, 3'd2, 16'h0, 1, 0, "R5 invalid entry");
    doReq(3, 12'h00F, 2, 3'd0, 16'h200F, 1, 0, "R6 exec allowed");
    doReq(3, 12'h010, 2, 3'd4, 16'h0, 0, 2, "R7 exec over limit");
    doReq(3, 12'h010, 0, 3'd3, 16'h0, 0, 2, "R6 rights before limit");
    doReq(3, 12'h001, 3, 3'd3, 16'h0, 0, 2, "R6 reserved code");
    doReq(1, 12'h7FF, 1, 3'd0, 16'h00FF, 1, 0, "R8 wrap sum");
    doReq(1, 12'h000, 2, 3'd0, 16'hF900, 0, 2, "R9 hit seg1");

    // R10: table write empties the copy
    cfgWrite(1'b1, 16'h0004);
    doReq(1, 12'h001, 0, 3'd0, 16'hF901, 1, 0, "R10 refetch after write");

    // R2 R4: origin moved
    cfgWrite(1'b0, 16'h0048);
    doReq(1, 12'h01F, 1, 3'd0, 16'h301F, 1, 0, "R2 moved origin");
    chk(lastRdAddr == 16'h0049, "R4 entry address moved", lastRdAddr, 16'h0049);
    cfgWrite(1'b0, 16'h0040);

    // R10: write in the check cycle shrinks count, check delayed
    doReq(3, 12'h001, 2, 3'd1, 16'h0, 0, 3, "R10 write in check cycle", 1, 1'b1, 16'h0003);
    cfgWrite(1'b1, 16'h0004);

    // R10: write in the cycle data returns, entry not retained
    doReq(0, 12'h001, 0, 3'd0, 16'h1001, 1, 4, "R10 write at fill", 3, 1'b1, 16'h0004);
    doReq(0, 12'h002, 0, 3'd0, 16'h1002, 1, 4, "R10 refetch after fill clash");
    doReq(0, 12'h003, 0, 3'd0, 16'h1003, 0, 2, "R9 retained after clean fill");

    // R10: write during first outstanding cycle
    doReq(3, 12'h002, 2, 3'd0, 16'h2002, 1, 4, "R10 write while outstanding", 2, 1'b1, 16'h0004);
    doReq(3, 12'h003, 2, 3'd0, 16'h2003, 1, 4, "R10 refetch after stale fill");

    repeat (5) @(negedge clk);
    chk(rspCount == reqCount, "R11 one response per request", rspCount, reqCount);
    chk(q.size() == 0, "R11 no missing response", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule